// File: doc/BRIEF.md
# Scanline Display Status and Interrupt Generator

This block is the line and frame timebase of a display controller. A cycle counter cuts every scanline into an active-draw interval followed by a horizontal-blank interval. A line counter runs through the visible lines and then through the vertical-blank lines before it returns to zero. From these two counters the block keeps three live status flags up to date: in-hblank, in-vblank and line-match. It also raises single-cycle interrupt requests for the flags whose enables are set.

The same timebase drives the renderers. At hblank entry on each visible line the block pulses a render strobe and gives the line number. A second strobe runs a fixed number of lines ahead of it for a pipelined renderer. On the last lines of a frame that second strobe wraps round to the top lines of the next frame. A one-cycle frame-start pulse marks the return of the line count to zero.

Software sees a 16-bit status word and a read-only line-count word. It writes the status word through a plain write-enable port. A write sets the interrupt enables and the line-match value, and it never disturbs the live flags.

Top module: `scanline_status_gen`

## Requirements
- R1: The status bit 1 (in-hblank) is 1 exactly in the cycles of the hblank interval. On each line, cycles 0 to LINE_CYCLES-HBLANK_CYCLES-1 are draw and the remaining HBLANK_CYCLES cycles are hblank. The bit clears when the next line's draw begins.
- R2: irq_hblank pulses for one cycle, in the first hblank cycle of every line, if status bit 4 (hblank interrupt enable) was set.
- R3: line_rd increments by one at each line start and wraps from TOTAL_LINES-1 to 0.
- R4: At each line start, status bit 2 (match) is set when the new line count equals the match value and is cleared otherwise. If status bit 5 is set, irq_match pulses for one cycle with it. The match value is held as status bits [15:8] (low 8 bits) plus bit 7 (ninth bit).
- R5: When the line count becomes VISIBLE_LINES, status bit 0 (in-vblank) sets. If status bit 3 is set, irq_vblank pulses for one cycle.
- R6: Status bit 0 clears when the line count becomes TOTAL_LINES-1, one line before the wrap.
- R7: A write stores bits [15:7] and [5:3] of wr_data in the next cycle. Bit 6 reads as 0. The written values of bits [2:0] have no effect on the flags.
- R8: frame_start pulses for one cycle when the line count becomes 0 through the wrap.
- R9: On a line below VISIBLE_LINES, render_stb pulses in the first hblank cycle, with render_line equal to the current line.
- R10: In the first hblank cycle, ahead_stb pulses with ahead_line = line+AHEAD_LINES on a visible line. On the last AHEAD_LINES lines of a frame it gives line+AHEAD_LINES-TOTAL_LINES instead. On any other line it stays low.
- R11: A synchronous active-high reset clears the line count, all flags, enables, match value and pulses, and restarts the line at its first draw cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Value written to the status word |
| stat_rd | output | 16 | Status word: flags [2:0], enables [5:3], match value [15:8] and bit 7 |
| line_rd | output | 16 | Current line count, zero-extended |
| irq_hblank | output | 1 | Hblank interrupt request pulse |
| irq_vblank | output | 1 | Vblank interrupt request pulse |
| irq_match | output | 1 | Line-match interrupt request pulse |
| frame_start | output | 1 | Pulse when the line count wraps to 0 |
| render_stb | output | 1 | Render strobe for the current visible line |
| render_line | output | $clog2(TOTAL_LINES) | Line to render with render_stb |
| ahead_stb | output | 1 | Render strobe for the line-ahead renderer |
| ahead_line | output | $clog2(TOTAL_LINES) | Line to render with ahead_stb |

## Verification
The bench aims at the frame edges. The vblank flag must rise at the first blank line and fall one line early at the last line. A design that cleared it at the wrap would show the flag for a whole extra line. The ahead strobe has to switch from the line+offset form to the wrapped form on the last lines, so a missing wrap shows up as an out-of-range line number or as a gap in the per-frame strobe count. Writes that try to set the flag bits must leave them untouched, and writes that land on the same cycle as a line start must not have the new enable or match value act until the next event. A design with an off-by-one in the draw/hblank split would move every strobe and interrupt by one cycle against the reference model.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    localparam int REG_W   = 16;
    localparam int MATCH_W = 9;

    typedef struct packed {
        logic match;
        logic hblank;
        logic vblank;
    } flags_t;

    typedef struct packed {
        logic [MATCH_W-1:0] match_line;
        logic               en_match;
        logic               en_hblank;
        logic               en_vblank;
    } ctrl_t;

    typedef struct packed {
        logic hb_enter;
        logic line_start;
    } evt_t;

    // Argument is {wr[15:7], wr[5:3]}: the only writable bits.
    function automatic ctrl_t ctrl_from_bits(input logic [11:0] b);
        ctrl_t c;
        c.match_line = {b[3], b[11:4]};
        c.en_match   = b[2];
        c.en_hblank  = b[1];
        c.en_vblank  = b[0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] stat_word(input ctrl_t c, input flags_t f);
        return {c.match_line[7:0], c.match_line[8], 1'b0,
                c.en_match, c.en_hblank, c.en_vblank,
                f.match, f.hblank, f.vblank};
    endfunction

endpackage

// File: rtl/lsg_line_timer.sv
module lsg_line_timer
    import lsg_pkg::*;
#(
    parameter int LINE_CYCLES   = 355,
    parameter int HBLANK_CYCLES = 99,
    parameter int TOTAL_LINES   = 263,
    parameter int LW            = 9
) (
    input  logic          clk,
    input  logic          rst,
    output logic [LW-1:0] line_q,
    output logic [LW-1:0] next_line,
    output evt_t          ev,
    output logic          frame_start
);
    localparam int CW = $clog2(LINE_CYCLES);
    localparam logic [CW-1:0] LAST_C  = CW'(LINE_CYCLES - 1);
    localparam logic [CW-1:0] HB_PRE  = CW'(LINE_CYCLES - HBLANK_CYCLES - 1);
    localparam logic [LW-1:0] LAST_LN = LW'(TOTAL_LINES - 1);

    logic [CW-1:0] cyc_q;

    always_comb begin
        ev.hb_enter   = (cyc_q == HB_PRE);
        ev.line_start = (cyc_q == LAST_C);
        next_line     = (line_q == LAST_LN) ? '0 : line_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q       <= '0;
            line_q      <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (ev.line_start) begin
                cyc_q       <= '0;
                line_q      <= next_line;
                frame_start <= (next_line == '0);
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsg_status_reg.sv
module lsg_status_reg
    import lsg_pkg::*;
#(
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int LW            = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev,
    input  logic [LW-1:0]    next_line,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] stat_q,
    output logic             irq_hblank,
    output logic             irq_vblank,
    output logic             irq_match
);
    localparam logic [LW-1:0] VBL_ON  = LW'(VISIBLE_LINES);
    localparam logic [LW-1:0] VBL_OFF = LW'(TOTAL_LINES - 1);

    flags_t flags_q;
    ctrl_t  ctrl_q;
    logic   hit;
    logic   unused_wr;

    assign unused_wr = ^{wr_data[6], wr_data[2:0]};
    assign hit       = (MATCH_W'(next_line) == ctrl_q.match_line);
    assign stat_q    = stat_word(ctrl_q, flags_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            ctrl_q     <= '0;
            irq_hblank <= 1'b0;
            irq_vblank <= 1'b0;
            irq_match  <= 1'b0;
        end else begin
            irq_hblank <= 1'b0;
            irq_vblank <= 1'b0;
            irq_match  <= 1'b0;
            if (ev.hb_enter) begin
                flags_q.hblank <= 1'b1;
                irq_hblank     <= ctrl_q.en_hblank;
            end
            if (ev.line_start) begin
                flags_q.hblank <= 1'b0;
                flags_q.match  <= hit;
                irq_match      <= hit & ctrl_q.en_match;
                if (next_line == VBL_ON) begin
                    flags_q.vblank <= 1'b1;
                    irq_vblank     <= ctrl_q.en_vblank;
                end else if (next_line == VBL_OFF) begin
                    flags_q.vblank <= 1'b0;
                end
            end
            if (wr_en) begin
                ctrl_q <= ctrl_from_bits({wr_data[15:7], wr_data[5:3]});
            end
        end
    end
endmodule

// File: rtl/lsg_render_sched.sv
module lsg_render_sched #(
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int AHEAD_LINES   = 48,
    parameter int LW            = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hb_enter,
    input  logic [LW-1:0] line_q,
    output logic          render_stb,
    output logic [LW-1:0] render_line,
    output logic          ahead_stb,
    output logic [LW-1:0] ahead_line
);
    localparam logic [LW-1:0] VIS_L = LW'(VISIBLE_LINES);

    logic visible;
    assign visible = (line_q < VIS_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            render_stb  <= 1'b0;
            render_line <= '0;
        end else begin
            render_stb <= hb_enter & visible;
            if (hb_enter & visible) render_line <= line_q;
        end
    end

    generate
        if (AHEAD_LINES > 0) begin : g_ahead
            localparam logic [LW-1:0] TAIL_L = LW'(TOTAL_LINES - AHEAD_LINES);
            localparam logic [LW-1:0] FWD    = LW'(AHEAD_LINES);
            localparam logic [LW-1:0] BACK   = LW'(TOTAL_LINES - AHEAD_LINES);
            logic tail;
            assign tail = (line_q >= TAIL_L);
            always_ff @(posedge clk) begin
                if (rst) begin
                    ahead_stb  <= 1'b0;
                    ahead_line <= '0;
                end else begin
                    ahead_stb <= hb_enter & (visible | tail);
                    if (hb_enter & visible)   ahead_line <= line_q + FWD;
                    else if (hb_enter & tail) ahead_line <= line_q - BACK;
                end
            end
        end else begin : g_no_ahead
            assign ahead_stb  = 1'b0;
            assign ahead_line = '0;
        end
    endgenerate
endmodule

// File: rtl/scanline_status_gen.sv
module scanline_status_gen
    import lsg_pkg::*;
#(
    parameter int LINE_CYCLES   = 355,
    parameter int HBLANK_CYCLES = 99,
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int AHEAD_LINES   = 48,
    localparam int LW           = $clog2(TOTAL_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [15:0]   wr_data,
    output logic [15:0]   stat_rd,
    output logic [15:0]   line_rd,
    output logic          irq_hblank,
    output logic          irq_vblank,
    output logic          irq_match,
    output logic          frame_start,
    output logic          render_stb,
    output logic [LW-1:0] render_line,
    output logic          ahead_stb,
    output logic [LW-1:0] ahead_line
);
    logic [LW-1:0] line_q;
    logic [LW-1:0] next_line;
    evt_t          ev;

    lsg_line_timer #(
        .LINE_CYCLES(LINE_CYCLES), .HBLANK_CYCLES(HBLANK_CYCLES),
        .TOTAL_LINES(TOTAL_LINES), .LW(LW)
    ) u_timer (
        .clk(clk), .rst(rst), .line_q(line_q), .next_line(next_line),
        .ev(ev), .frame_start(frame_start)
    );

    lsg_status_reg #(
        .VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES), .LW(LW)
    ) u_status (
        .clk(clk), .rst(rst), .ev(ev), .next_line(next_line),
        .wr_en(wr_en), .wr_data(wr_data), .stat_q(stat_rd),
        .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_match(irq_match)
    );

    lsg_render_sched #(
        .VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES),
        .AHEAD_LINES(AHEAD_LINES), .LW(LW)
    ) u_render (
        .clk(clk), .rst(rst), .hb_enter(ev.hb_enter), .line_q(line_q),
        .render_stb(render_stb), .render_line(render_line),
        .ahead_stb(ahead_stb), .ahead_line(ahead_line)
    );

    assign line_rd = 16'(line_q);
endmodule

// File: rtl/scanline_status_gen_chk.sv
module scanline_status_gen_chk #(
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int LW            = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [15:0]   wr_data,
    input logic [15:0]   stat_rd,
    input logic [15:0]   line_rd,
    input logic          irq_hblank,
    input logic          irq_vblank,
    input logic          irq_match,
    input logic          frame_start,
    input logic          render_stb,
    input logic [LW-1:0] render_line,
    input logic          ahead_stb,
    input logic [LW-1:0] ahead_line
);
    logic unused_chk;
    assign unused_chk = ^{wr_data[6], wr_data[2:0], stat_rd[6]};

    p_hb_irq_flag_r2: assert property (@(posedge clk) disable iff (rst)
        irq_hblank |-> stat_rd[1]);
    p_hb_irq_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        irq_hblank |=> !irq_hblank);
    p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_rd) |-> (line_rd == $past(line_rd) + 16'd1) || (line_rd == 16'd0));
    p_line_range_r3: assert property (@(posedge clk) disable iff (rst)
        line_rd < 16'(TOTAL_LINES));
    p_match_irq_r4: assert property (@(posedge clk) disable iff (rst)
        irq_match |-> stat_rd[2] && (line_rd == {7'd0, stat_rd[7], stat_rd[15:8]}));
    p_vbl_irq_r5: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |-> stat_rd[0] && (line_rd == 16'(VISIBLE_LINES)));
    p_vbl_last_r6: assert property (@(posedge clk) disable iff (rst)
        (line_rd == 16'(TOTAL_LINES - 1)) |-> !stat_rd[0]);
    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> {stat_rd[15:7], stat_rd[5:3]} == $past({wr_data[15:7], wr_data[5:3]}));
    p_frame_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_rd == 16'd0);
    p_render_r9: assert property (@(posedge clk) disable iff (rst)
        render_stb |-> stat_rd[1] && (16'(render_line) == line_rd));
    p_ahead_r10: assert property (@(posedge clk) disable iff (rst)
        ahead_stb |-> stat_rd[1] && (ahead_line < LW'(TOTAL_LINES)));
endmodule

bind scanline_status_gen scanline_status_gen_chk #(
    .VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES), .LW(LW)
) u_chk (.*);

// File: tb/scanline_status_gen_test.sv
module scanline_status_gen_test;
    localparam int LC  = 10;
    localparam int HB  = 4;
    localparam int VIS = 30;
    localparam int TOT = 40;
    localparam int AH  = 8;
    localparam int LW  = $clog2(TOT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] stat_rd, line_rd;
    logic irq_hblank, irq_vblank, irq_match, frame_start, render_stb, ahead_stb;
    logic [LW-1:0] render_line, ahead_line;

    always #10 clk = ~clk;

    scanline_status_gen #(
        .LINE_CYCLES(LC), .HBLANK_CYCLES(HB), .VISIBLE_LINES(VIS),
        .TOTAL_LINES(TOT), .AHEAD_LINES(AH)
    ) uut (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference model
    int m_cyc, m_line, m_mset, nl;
    bit m_hb, m_vb, m_match, m_en_h, m_en_v, m_en_m;
    bit e_ih, e_iv, e_im, e_fs, e_rs, e_as;
    int e_rl, e_al;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_line = 0; m_mset = 0;
            m_hb = 0; m_vb = 0; m_match = 0; m_en_h = 0; m_en_v = 0; m_en_m = 0;
            e_ih = 0; e_iv = 0; e_im = 0; e_fs = 0; e_rs = 0; e_as = 0;
        end else begin
            e_ih = 0; e_iv = 0; e_im = 0; e_fs = 0; e_rs = 0; e_as = 0;
            if (m_cyc == LC - HB - 1) begin
                m_hb = 1;
                e_ih = m_en_h;
                if (m_line < VIS) begin
                    e_rs = 1; e_rl = m_line; e_as = 1; e_al = m_line + AH;
                end else if (m_line >= TOT - AH) begin
                    e_as = 1; e_al = m_line + AH - TOT;
                end
            end
            if (m_cyc == LC - 1) begin
                nl = (m_line + 1) % TOT;
                m_hb = 0;
                m_match = (nl == m_mset);
                e_im = m_match && m_en_m;
                if (nl == VIS) begin m_vb = 1; e_iv = m_en_v; end
                if (nl == TOT - 1) m_vb = 0;
                e_fs = (nl == 0);
                m_line = nl;
            end
            if (wr_en) begin
                m_mset = int'(wr_data[15:8]) + (wr_data[7] ? 256 : 0);
                m_en_m = wr_data[5]; m_en_h = wr_data[4]; m_en_v = wr_data[3];
            end
            m_cyc = (m_cyc + 1) % LC;
        end
    end

    // Per-clock comparison against the model
    int n_ih, n_iv, n_im, n_rs, n_as, n_fs;
    always @(negedge clk) begin
        if (!rst) begin
            check("R1 hblank flag", int'(stat_rd[1]), int'(m_hb));
            check("R2 irq_hblank", int'(irq_hblank), int'(e_ih));
            check("R3 line count", int'(line_rd), m_line);
            check("R4 match flag", int'(stat_rd[2]), int'(m_match));
            check("R4 irq_match", int'(irq_match), int'(e_im));
            check("R5 R6 vblank flag", int'(stat_rd[0]), int'(m_vb));
            check("R5 irq_vblank", int'(irq_vblank), int'(e_iv));
            check("R7 control bits", int'(stat_rd[15:3]),
                  ((m_mset & 255) << 5) | (((m_mset >> 8) & 1) << 4)
                  | (int'(m_en_m) << 2) | (int'(m_en_h) << 1) | int'(m_en_v));
            check("R8 frame_start", int'(frame_start), int'(e_fs));
            check("R9 render_stb", int'(render_stb), int'(e_rs));
            if (e_rs) check("R9 render_line", int'(render_line), e_rl);
            check("R10 ahead_stb", int'(ahead_stb), int'(e_as));
            if (e_as) check("R10 ahead_line", int'(ahead_line), e_al);
            n_ih += int'(irq_hblank); n_iv += int'(irq_vblank); n_im += int'(irq_match);
            n_rs += int'(render_stb); n_as += int'(ahead_stb); n_fs += int'(frame_start);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 60000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_stat(input logic [15:0] v);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input int e_h, input int e_v, input int e_m);
        while (!frame_start) begin @(negedge clk); #1; end
        n_ih = 0; n_iv = 0; n_im = 0; n_rs = 0; n_as = 0; n_fs = 0;
        repeat (TOT * LC) @(negedge clk);
        #1;
        check("R2 hblank irqs per frame", n_ih, e_h);
        check("R5 vblank irqs per frame", n_iv, e_v);
        check("R4 match irqs per frame", n_im, e_m);
        check("R9 render strobes per frame", n_rs, VIS);
        check("R10 ahead strobes per frame", n_as, VIS + AH);
        check("R8 frame starts per frame", n_fs, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R11: reset state
        check("R11 status after reset", int'(stat_rd), 0);
        check("R11 line after reset", int'(line_rd), 0);
        check("R11 pulses after reset",
              int'({irq_hblank, irq_vblank, irq_match, frame_start, render_stb, ahead_stb}), 0);
        // R7: written flag bits ignored (no event in the next cycle)
        wr_en = 1'b1; wr_data = 16'h0007;
        @(negedge clk); #1;
        wr_en = 1'b0;
        check("R7 flag bits after write", int'(stat_rd[2:0]), 0);
        check("R7 bit 6 reads zero", int'(stat_rd[6]), 0);
        // All enables, match line 5
        write_stat(16'h0500 | 16'h0038 | 16'h0047);
        check("R7 readback", int'(stat_rd), 16'h0538);
        run_frame(TOT, 1, 1);
        // Match inside vblank, only hblank enabled; ninth match bit checked too
        write_stat(16'h2310);
        run_frame(TOT, 0, 0);
        write_stat(16'h2328);
        run_frame(0, 1, 1);
        write_stat(16'h0080 | 16'h0038);
        check("R7 ninth match bit readback", int'(stat_rd[7]), 1);
        run_frame(TOT, 1, 0);
        // Mid-frame reset
        repeat (137) @(negedge clk);
        #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        check("R11 line after mid-frame reset", int'(line_rd), 0);
        check("R11 status after mid-frame reset", int'(stat_rd), 0);
        write_stat(16'h0038);
        run_frame(TOT, 1, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule